// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, every cycle, how the inter-stage registers of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) should move. It compares the source registers of the instruction in decode against the destination registers of the older instructions in execute and memory. It raises a single stall when a dependence cannot be served. It also drives the write enables and synchronous clears of the PC, fetch/decode and decode/execute registers. A bubble is a register cleared to all zeros, because the all-zero opcode is a no-op.

A static input chooses between two operating modes. In stall-only mode, any dependence on execute or memory holds decode. Writeback needs no hold, because the register file is written on the opposite clock edge and the decode read sees the new value. In forwarding mode, the only hold is for a load in execute that feeds decode. Operands read in execute are then steered from the memory or writeback stage, and the nearer stage wins. A taken branch resolved in execute flushes fetch and decode, and it overrides any stall. Two event counters track elapsed cycles and retired non-no-op instructions.

Top module: `hazard_ctrl`

## Requirements
- R1: With `bypass_en`=0, `stall` is 1 when a non-zero source of decode (`d_rs1` or `d_rs2`) equals `x_rd` with `x_we`=1 or `m_rd` with `m_we`=1, provided `x_br_taken`=0.
- R2: A match against the writeback destination alone (`w_rd`, `w_we`=1) never causes a stall in either mode.
- R3: With `bypass_en`=1, `stall` is 1 only when `x_is_load`=1, `x_we`=1, `x_rd` is non-zero and equals `d_rs1` or `d_rs2`, and `x_br_taken`=0.
- R4: With `bypass_en`=1, each operand select (`fwd_a` for `x_rs1`, `fwd_b` for `x_rs2`) is 2 (memory) on a match with `m_rd`/`m_we`. Otherwise it is 1 (writeback) on a match with `w_rd`/`w_we`, otherwise 0 (register file). Memory has priority over writeback.
- R5: With `bypass_en`=0, both operand selects are 0.
- R6: Register 0 and any stage whose write enable is 0 never count as a producer for stalls or forwarding.
- R7: While `stall`=1: `pc_we`=0, `fd_we`=0, `fd_clr`=0 and `dx_clr`=1.
- R8: When `x_br_taken`=1: `stall`=0, `pc_we`=1, `fd_clr`=1 and `dx_clr`=1, whatever the register comparisons say.
- R9: With neither stall nor flush: `pc_we`=1, `fd_we`=1, `fd_clr`=0, `dx_clr`=0.
- R10: `cycle_cnt` is 0 during reset and increases by one on every clock edge after reset.
- R11: `retire_cnt` is 0 during reset and increases by one on each clock edge where `w_opcode` is non-zero (opcode 0 is the no-op).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the counters |
| bypass_en | input | 1 | 1 selects forwarding mode, 0 selects stall-only mode |
| d_rs1 | input | REG_W | First source register of the decode instruction |
| d_rs2 | input | REG_W | Second source register of the decode instruction |
| x_rs1 | input | REG_W | First source register of the execute instruction |
| x_rs2 | input | REG_W | Second source register of the execute instruction |
| x_rd | input | REG_W | Destination register in execute |
| x_we | input | 1 | Execute instruction writes a register |
| x_is_load | input | 1 | Execute instruction is a load |
| x_br_taken | input | 1 | Taken branch resolved in execute |
| m_rd | input | REG_W | Destination register in memory stage |
| m_we | input | 1 | Memory-stage instruction writes a register |
| w_rd | input | REG_W | Destination register in writeback |
| w_we | input | 1 | Writeback instruction writes a register |
| w_opcode | input | OP_W | Opcode of the writeback instruction |
| stall | output | 1 | Decode is held this cycle |
| pc_we | output | 1 | PC write enable |
| fd_we | output | 1 | Fetch/decode register write enable |
| fd_clr | output | 1 | Clear fetch/decode register to a no-op |
| dx_clr | output | 1 | Clear decode/execute register to a no-op |
| fwd_a | output | 2 | Operand A source: 0 register file, 1 writeback, 2 memory |
| fwd_b | output | 2 | Operand B source: 0 register file, 1 writeback, 2 memory |
| cycle_cnt | output | CNT_W | Elapsed cycles since reset |
| retire_cnt | output | CNT_W | Non-no-op instructions retired since reset |

## Verification
On every cycle, the assertions check the relations that hold at the ports. Flush overrides stall. A stall freezes the PC and fetch/decode and clears decode/execute. Forwarding mode holds only for a loaded value, and stall-only mode keeps both operand selects at the register file. Both counters follow their per-cycle increment rules. The full decision surface can only be shown by the bench's scenarios. These cover every combination of source and destination names on a small register file, across both modes, with and without a branch. They include the register-0 cases, disabled producers, writeback-only matches and memory-over-writeback priority.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int MAX_REG_W = 8;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;

  // A stage feeds a source only if it writes, targets a real register and names that source.
  function automatic logic feeds(input logic [MAX_REG_W-1:0] src,
                                 input logic [MAX_REG_W-1:0] dst,
                                 input logic                 wr);
    return wr && (dst != '0) && (dst == src);
  endfunction

  function automatic fwd_sel_e pick_source(input logic byp, input logic from_mem,
                                           input logic from_wb);
    if (!byp)     return FWD_RF;
    if (from_mem) return FWD_MEM;
    if (from_wb)  return FWD_WB;
    return FWD_RF;
  endfunction

endpackage

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] d_src,
  input  logic [REG_W-1:0]           x_rd,
  input  logic                       x_we,
  input  logic                       x_is_load,
  input  logic [REG_W-1:0]           m_rd,
  input  logic                       m_we,
  input  logic                       bypass_en,
  output logic                       raw_x_hit,
  output logic                       raw_m_hit,
  output logic                       load_use_hit,
  output logic                       stall_req
);
  logic [NSRC-1:0] hit_x, hit_m;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign hit_x[s] = feeds(MAX_REG_W'(d_src[s]), MAX_REG_W'(x_rd), x_we);
    assign hit_m[s] = feeds(MAX_REG_W'(d_src[s]), MAX_REG_W'(m_rd), m_we);
  end

  assign raw_x_hit    = |hit_x;
  assign raw_m_hit    = |hit_m;
  assign load_use_hit = raw_x_hit && x_is_load;
  assign stall_req    = bypass_en ? load_use_hit : (raw_x_hit || raw_m_hit);
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic [NSRC-1:0][REG_W-1:0] x_src,
  input  logic [REG_W-1:0]           m_rd,
  input  logic                       m_we,
  input  logic [REG_W-1:0]           w_rd,
  input  logic                       w_we,
  input  logic                       bypass_en,
  output logic [NSRC-1:0][1:0]       sel
);
  for (genvar s = 0; s < NSRC; s++) begin : g_path
    logic from_mem, from_wb;
    assign from_mem = feeds(MAX_REG_W'(x_src[s]), MAX_REG_W'(m_rd), m_we);
    assign from_wb  = feeds(MAX_REG_W'(x_src[s]), MAX_REG_W'(w_rd), w_we);
    assign sel[s]   = pick_source(bypass_en, from_mem, from_wb);
  end
endmodule

// File: rtl/hz_latch_ctrl.sv
module hz_latch_ctrl (
  input  logic stall_req,
  input  logic flush,
  output logic stall,
  output logic pc_we,
  output logic fd_we,
  output logic fd_clr,
  output logic dx_clr
);
  always_comb begin
    stall  = stall_req && !flush;
    pc_we  = !stall;
    fd_we  = !stall;
    fd_clr = flush;
    dx_clr = flush || stall;
  end
endmodule

// File: rtl/hz_perf_cnt.sv
module hz_perf_cnt #(
  parameter int CNT_W = 32,
  parameter int OP_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  w_opcode,
  output logic             retire_evt,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] retire_cnt
);
  assign retire_evt = (w_opcode != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_cnt  <= '0;
      retire_cnt <= '0;
    end else begin
      cycle_cnt  <= cycle_cnt + 1'b1;
      if (retire_evt) retire_cnt <= retire_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int OP_W  = 4,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bypass_en,
  input  logic [REG_W-1:0] d_rs1,
  input  logic [REG_W-1:0] d_rs2,
  input  logic [REG_W-1:0] x_rs1,
  input  logic [REG_W-1:0] x_rs2,
  input  logic [REG_W-1:0] x_rd,
  input  logic             x_we,
  input  logic             x_is_load,
  input  logic             x_br_taken,
  input  logic [REG_W-1:0] m_rd,
  input  logic             m_we,
  input  logic [REG_W-1:0] w_rd,
  input  logic             w_we,
  input  logic [OP_W-1:0]  w_opcode,
  output logic             stall,
  output logic             pc_we,
  output logic             fd_we,
  output logic             fd_clr,
  output logic             dx_clr,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] retire_cnt
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_W-1:0] d_src, x_src;
  logic [NSRC-1:0][1:0]       sel;
  logic raw_x_hit, raw_m_hit, load_use_hit, stall_req, retire_evt;

  assign d_src = {d_rs2, d_rs1};
  assign x_src = {x_rs2, x_rs1};

  hz_stall_unit #(.REG_W(REG_W), .NSRC(NSRC)) u_stall (
    .d_src(d_src), .x_rd(x_rd), .x_we(x_we), .x_is_load(x_is_load),
    .m_rd(m_rd), .m_we(m_we), .bypass_en(bypass_en),
    .raw_x_hit(raw_x_hit), .raw_m_hit(raw_m_hit),
    .load_use_hit(load_use_hit), .stall_req(stall_req)
  );

  hz_fwd_unit #(.REG_W(REG_W), .NSRC(NSRC)) u_fwd (
    .x_src(x_src), .m_rd(m_rd), .m_we(m_we), .w_rd(w_rd), .w_we(w_we),
    .bypass_en(bypass_en), .sel(sel)
  );

  hz_latch_ctrl u_latch (
    .stall_req(stall_req), .flush(x_br_taken), .stall(stall),
    .pc_we(pc_we), .fd_we(fd_we), .fd_clr(fd_clr), .dx_clr(dx_clr)
  );

  hz_perf_cnt #(.CNT_W(CNT_W), .OP_W(OP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .w_opcode(w_opcode), .retire_evt(retire_evt),
    .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
  );

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];
endmodule

// File: rtl/hz_checks.sv
module hz_checks #(
  parameter int REG_W = 5,
  parameter int OP_W  = 4,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bypass_en,
  input logic [REG_W-1:0] d_rs1,
  input logic [REG_W-1:0] d_rs2,
  input logic [REG_W-1:0] x_rd,
  input logic             x_we,
  input logic             x_is_load,
  input logic             x_br_taken,
  input logic [OP_W-1:0]  w_opcode,
  input logic             stall,
  input logic             pc_we,
  input logic             fd_we,
  input logic             fd_clr,
  input logic             dx_clr,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             load_use_hit,
  input logic [CNT_W-1:0] cycle_cnt,
  input logic [CNT_W-1:0] retire_cnt
);
  a_r8_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
    x_br_taken |-> (!stall && pc_we && fd_clr && dx_clr));

  a_r7_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !fd_we && !fd_clr && dx_clr));

  a_r9_free_flow: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !x_br_taken) |-> (pc_we && fd_we && !fd_clr && !dx_clr));

  a_r3_only_load_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && !x_is_load) |-> !stall);

  a_r3_load_use_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_en && load_use_hit && !x_br_taken) |-> stall);

  a_r6_zero_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (d_rs1 == '0 && d_rs2 == '0) |-> !stall);

  a_r6_no_writer: assert property (@(posedge clk) disable iff (!rst_n)
    (!x_we && bypass_en) |-> !stall);

  a_r5_rf_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_en |-> (fwd_a == 2'd0 && fwd_b == 2'd0));

  a_r4_legal_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'd3 && fwd_b != 2'd3));

  a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cycle_cnt == $past(cycle_cnt) + 1'b1));

  a_r11_noop_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (w_opcode == '0) |=> $stable(retire_cnt));

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (w_opcode != '0) |=> (retire_cnt == $past(retire_cnt) + 1'b1));
endmodule

bind hazard_ctrl hz_checks #(.REG_W(REG_W), .OP_W(OP_W), .CNT_W(CNT_W)) u_hz_checks (
  .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .d_rs1(d_rs1), .d_rs2(d_rs2),
  .x_rd(x_rd), .x_we(x_we), .x_is_load(x_is_load), .x_br_taken(x_br_taken),
  .w_opcode(w_opcode), .stall(stall), .pc_we(pc_we), .fd_we(fd_we),
  .fd_clr(fd_clr), .dx_clr(dx_clr), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .load_use_hit(load_use_hit), .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int REG_W = 2;
  localparam int OP_W  = 4;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass_en = 1'b0;
  logic [REG_W-1:0] d_rs1 = '0, d_rs2 = '0, x_rs1 = '0, x_rs2 = '0;
  logic [REG_W-1:0] x_rd = '0, m_rd = '0, w_rd = '0;
  logic x_we = 1'b0, x_is_load = 1'b0, x_br_taken = 1'b0, m_we = 1'b0, w_we = 1'b0;
  logic [OP_W-1:0] w_opcode = '0;
  logic stall, pc_we, fd_we, fd_clr, dx_clr;
  logic [1:0] fwd_a, fwd_b;
  logic [CNT_W-1:0] cycle_cnt, retire_cnt;

  int compared = 0;
  int mismatched = 0;
  longint exp_cyc = 0;
  longint exp_ret = 0;

  always #2 clk = ~clk;  // 250 MHz

  hazard_ctrl #(.REG_W(REG_W), .OP_W(OP_W), .CNT_W(CNT_W)) i_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en), .d_rs1(d_rs1), .d_rs2(d_rs2),
    .x_rs1(x_rs1), .x_rs2(x_rs2), .x_rd(x_rd), .x_we(x_we), .x_is_load(x_is_load),
    .x_br_taken(x_br_taken), .m_rd(m_rd), .m_we(m_we), .w_rd(w_rd), .w_we(w_we),
    .w_opcode(w_opcode), .stall(stall), .pc_we(pc_we), .fd_we(fd_we),
    .fd_clr(fd_clr), .dx_clr(dx_clr), .fwd_a(fwd_a), .fwd_b(fwd_b),
    .cycle_cnt(cycle_cnt), .retire_cnt(retire_cnt)
  );

  // Independent reference counters (R10, R11)
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_cyc <= 0;
      exp_ret <= 0;
    end else begin
      exp_cyc <= exp_cyc + 1;
      if (w_opcode != 0) exp_ret <= exp_ret + 1;
    end
  end

  function automatic bit dep(int src, int dst, bit wr);
    if (!wr) return 0;
    if (dst == 0) return 0;  // R6: register 0 is never produced
    return src == dst;
  endfunction

  task automatic check(string req, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset cycle", cycle_cnt, 0);
    check("R11 reset retire", retire_cnt, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 65536; i++) begin
      int s1, s2, xr, mr, wr, mode;
      bit xw, xl, mw, ww, br, want_stall, hold;
      int want_a, want_b;
      @(negedge clk);
      s1 = i & 3; s2 = (i >> 2) & 3; xr = (i >> 4) & 3;
      xw = i[6]; xl = i[7]; mr = (i >> 8) & 3; mw = i[10];
      wr = (i >> 11) & 3; ww = i[13]; mode = i[14]; br = i[15];
      d_rs1 = REG_W'(s1); d_rs2 = REG_W'(s2);
      x_rs1 = REG_W'(s2); x_rs2 = REG_W'(s1);  // swapped to exercise each path separately
      x_rd = REG_W'(xr); x_we = xw; x_is_load = xl;
      m_rd = REG_W'(mr); m_we = mw; w_rd = REG_W'(wr); w_we = ww;
      bypass_en = mode[0]; x_br_taken = br;
      w_opcode = OP_W'(i % 3);
      #1;
      // stall-only: hold for execute or memory producers; writeback never holds (R2)
      if (mode == 0)
        hold = dep(s1, xr, xw) || dep(s2, xr, xw) || dep(s1, mr, mw) || dep(s2, mr, mw);
      else
        hold = xl && (dep(s1, xr, xw) || dep(s2, xr, xw));
      want_stall = hold && !br;  // R8 flush wins
      check(mode == 0 ? "R1/R2/R6 stall" : "R3/R2/R6 stall", stall, want_stall);
      if (br) begin
        check("R8 pc_we", pc_we, 1); check("R8 fd_clr", fd_clr, 1);
        check("R8 dx_clr", dx_clr, 1);
      end else if (want_stall) begin
        check("R7 pc_we", pc_we, 0); check("R7 fd_we", fd_we, 0);
        check("R7 fd_clr", fd_clr, 0); check("R7 dx_clr", dx_clr, 1);
      end else begin
        check("R9 pc_we", pc_we, 1); check("R9 fd_we", fd_we, 1);
        check("R9 fd_clr", fd_clr, 0); check("R9 dx_clr", dx_clr, 0);
      end
      want_a = 0; want_b = 0;
      if (mode != 0) begin
        want_a = dep(s2, mr, mw) ? 2 : (dep(s2, wr, ww) ? 1 : 0);
        want_b = dep(s1, mr, mw) ? 2 : (dep(s1, wr, ww) ? 1 : 0);
      end
      check(mode == 0 ? "R5 fwd_a" : "R4/R6 fwd_a", fwd_a, want_a);
      check(mode == 0 ? "R5 fwd_b" : "R4/R6 fwd_b", fwd_b, want_b);
      if ((i & 4095) == 4095) begin
        check("R10 cycle count", cycle_cnt, exp_cyc);
        check("R11 retire count", retire_cnt, exp_ret);
      end
    end

    // Directed: counters return to zero on reset, then run on
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", cycle_cnt, 0);
    check("R11 re-reset", retire_cnt, 0);
    rst_n = 1'b1;
    w_opcode = '0;
    repeat (5) @(negedge clk);
    check("R10 after reset", cycle_cnt, 5);
    check("R11 no-op only", retire_cnt, 0);
    w_opcode = OP_W'(1);
    repeat (3) @(negedge clk);
    check("R11 halt counts", retire_cnt, 3);
    check("R10 running", cycle_cnt, exp_cyc);
    summary();
  end
endmodule